// File: doc/BRIEF.md
# Cascadable presettable 4-bit counter

A small synchronous up-counter. It has a parallel preset, two count enables and a terminal-count carry. Two elaboration-time switches pick the counting range and the clear style. The counting range is either a full binary sweep of the state word or a decimal digit (0 to 9). The clear is either asynchronous or sampled on the clock. Every other state change happens on the rising clock edge.

Stages chain into wider counters without extra gates:
- All stages share the clock, the preset strobe and enable P.
- Each stage's carry drives enable T of the next stage up.
- The carry is a decode of the present state gated by T, with no register on it, so the whole chain steps on the same edge.

All pins are plain control or state pins, so no valid/ready handshake applies and nothing can stall the counter.

Top module: `casc_counter4`

## Requirements
- R1: Clear (`clr_n` low) takes priority over load and both enables, and the state reads zero after the next rising edge at the latest.
- R2: With `ASYNC_CLR=1`, the state reads zero while `clr_n` is low, before any clock edge arrives.
- R3: With `ASYNC_CLR=0`, pulling `clr_n` low leaves the state unchanged until the next rising edge, which sets it to zero.
- R4: With clear inactive and `load_n` low, the rising edge copies `din` into `q` (bit 0 is the least significant), whatever `en_p` and `en_t` are.
- R5: With clear and load inactive, the state holds if `en_p` or `en_t` is low.
- R6: With clear and load inactive and both enables high, the state rises by one on each rising edge.
- R7: The terminal value is 15 in binary mode (`DECADE=0`) and 9 in decade mode (`DECADE=1`). Counting from the terminal value gives 0.
- R8: In decade mode, a loaded value from 10 to 15 keeps rising by one per counting edge, with 15 going to 0. From there the state stays in the range 0 to 9.
- R9: `carry` is high exactly when `en_t` is high and `q` holds the terminal value. It follows these without a clock and does not depend on `en_p`.
- R10: Three binary stages, each stage's `carry` feeding the next stage's `en_t`, behave as one 12-bit counter with the same clear, load and enable rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; asynchronous or clocked per `ASYNC_CLR` |
| load_n | input | 1 | Active-low synchronous preset strobe |
| en_p | input | 1 | Count enable, does not affect carry |
| en_t | input | 1 | Count enable that also gates carry |
| din | input | WIDTH | Preset value |
| q | output | WIDTH | Counter state |
| carry | output | 1 | Terminal-count output for the next stage's `en_t` |

## Verification
Clear can arrive in the same cycle as a load or a counting step. The random stimulus lowers `clr_n` in some cycles while `load_n` is low or both enables are high, and the directed part forces clear and load together. The outcome is checked twice. Half a cycle after `clr_n` drops, the asynchronous variants must already read zero while the clocked variants still show their old value. After the edge, every variant must read zero, never the load data or the incremented value. Load and a terminal-count step also meet in the same cycle, and the bench checks there that the load wins and the carry follows the loaded value.

// File: rtl/casc_cnt_pkg.sv
`timescale 1ns/1ps
package casc_cnt_pkg;

  // Operation chosen for the next clock edge (clear is handled in the register).
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2
  } cnt_op_e;

  // Terminal value for a given mode and state width.
  function automatic int unsigned term_value(input int unsigned width, input bit decade);
    if (decade) return 9;
    return (1 << width) - 1;
  endfunction

endpackage

// File: rtl/casc_cnt_ctrl.sv
`timescale 1ns/1ps
module casc_cnt_ctrl
  import casc_cnt_pkg::*;
(
  input  logic    load_n,
  input  logic    en_p,
  input  logic    en_t,
  output cnt_op_e op
);

  // Load beats both enables; counting needs both enables high.
  always_comb begin
    if (!load_n)            op = OP_LOAD;
    else if (en_p && en_t)  op = OP_COUNT;
    else                    op = OP_HOLD;
  end

endmodule

// File: rtl/casc_cnt_next.sv
`timescale 1ns/1ps
module casc_cnt_next
  import casc_cnt_pkg::*;
#(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b0
) (
  input  cnt_op_e          op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt
);

  localparam logic [WIDTH-1:0] TERM = WIDTH'(term_value(WIDTH, DECADE));

  logic [WIDTH-1:0] incr;

  // Out-of-range decade states fall through to plain increment and wrap at all-ones.
  always_comb begin
    if (cur == TERM) incr = '0;
    else             incr = cur + WIDTH'(1);
  end

  always_comb begin
    unique case (op)
      OP_LOAD:  nxt = din;
      OP_COUNT: nxt = incr;
      default:  nxt = cur;
    endcase
  end

endmodule

// File: rtl/casc_cnt_reg.sv
`timescale 1ns/1ps
module casc_cnt_reg #(
  parameter int unsigned WIDTH     = 4,
  parameter bit          ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);

  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
    end
  endgenerate

endmodule

// File: rtl/casc_cnt_tc.sv
`timescale 1ns/1ps
module casc_cnt_tc
  import casc_cnt_pkg::*;
#(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b0
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_t,
  output logic             carry
);

  localparam logic [WIDTH-1:0] TERM = WIDTH'(term_value(WIDTH, DECADE));

  assign carry = en_t & (q == TERM);

endmodule

// File: rtl/casc_counter4.sv
`timescale 1ns/1ps
module casc_counter4
  import casc_cnt_pkg::*;
#(
  parameter int unsigned WIDTH     = 4,
  parameter bit          DECADE    = 1'b0,
  parameter bit          ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry
);

  cnt_op_e          op;
  logic [WIDTH-1:0] nxt;

  casc_cnt_ctrl u_ctrl (
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .op     (op)
  );

  casc_cnt_next #(.WIDTH(WIDTH), .DECADE(DECADE)) u_next (
    .op  (op),
    .cur (q),
    .din (din),
    .nxt (nxt)
  );

  casc_cnt_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .nxt   (nxt),
    .q     (q)
  );

  casc_cnt_tc #(.WIDTH(WIDTH), .DECADE(DECADE)) u_tc (
    .q     (q),
    .en_t  (en_t),
    .carry (carry)
  );

endmodule

// File: rtl/casc_counter4_chk.sv
`timescale 1ns/1ps
module casc_counter4_chk
  import casc_cnt_pkg::*;
#(
  parameter int unsigned WIDTH     = 4,
  parameter bit          DECADE    = 1'b0,
  parameter bit          ASYNC_CLR = 1'b1
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic             en_p,
  input logic             en_t,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             carry
);

  localparam logic [WIDTH-1:0] TERM = WIDTH'(term_value(WIDTH, DECADE));

  // R1: a sampled clear leaves zero one edge later
  a_r1_clear_wins: assert property (@(posedge clk) !clr_n |=> q == '0);

  generate
    if (ASYNC_CLR) begin : g_async_chk
      // R2: asynchronous variant is already zero while clear is low
      a_r2_async_zero: assert property (@(posedge clk) !clr_n |-> q == '0);
    end
  endgenerate

  // R4: load copies din regardless of the enables
  a_r4_load: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(din));

  // R5: a low enable holds the state
  a_r5_hold: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_p && en_t)) |=> $stable(q));

  // R6 / R8: non-terminal states step by one
  a_r6_step: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t && q != TERM) |=> q == WIDTH'($past(q) + WIDTH'(1)));

  // R7: terminal state wraps to zero
  a_r7_wrap: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t && q == TERM) |=> q == '0);

  // R9: carry only with T high at the terminal value, and always then
  a_r9_carry_needs_tc: assert property (@(posedge clk) disable iff (!clr_n)
    carry |-> (en_t && q == TERM));
  a_r9_carry_present: assert property (@(posedge clk) disable iff (!clr_n)
    (en_t && q == TERM) |-> carry);

endmodule

bind casc_counter4 casc_counter4_chk #(
  .WIDTH(WIDTH), .DECADE(DECADE), .ASYNC_CLR(ASYNC_CLR)
) u_chk (
  .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
  .din(din), .q(q), .carry(carry)
);

// File: tb/casc_counter4_tb.sv
`timescale 1ns/1ps
module casc_counter4_tb;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       clr_n  = 1'b0;
  logic       load_n = 1'b1;
  logic       en_p   = 1'b0;
  logic       en_t   = 1'b0;
  logic [3:0] din    = '0;

  // variant index: 0 bin/async, 1 bin/sync, 2 dec/async, 3 dec/sync
  logic [3:0] qv [4];
  logic       cv [4];
  localparam bit VDEC [4]   = '{1'b0, 1'b0, 1'b1, 1'b1};
  localparam bit VASYNC [4] = '{1'b1, 1'b0, 1'b1, 1'b0};

  casc_counter4 #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b1)) u_dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(qv[0]), .carry(cv[0]));
  casc_counter4 #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u_dut_bs (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(qv[1]), .carry(cv[1]));
  casc_counter4 #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) u_dut_da (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(qv[2]), .carry(cv[2]));
  casc_counter4 #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b0)) u_dut_ds (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(qv[3]), .carry(cv[3]));

  // three-stage binary cascade (R10)
  logic        ct0 = 1'b0;
  logic [11:0] cdin = '0;
  logic [11:0] cq;
  logic [2:0]  cc;

  casc_counter4 #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u_cas0 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(ct0),
    .din(cdin[3:0]), .q(cq[3:0]), .carry(cc[0]));
  casc_counter4 #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u_cas1 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(cc[0]),
    .din(cdin[7:4]), .q(cq[7:4]), .carry(cc[1]));
  casc_counter4 #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u_cas2 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(cc[1]),
    .din(cdin[11:8]), .q(cq[11:8]), .carry(cc[2]));

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [3:0]  mdl [4];
  logic [11:0] cmdl;

  function automatic logic [3:0] term_of(bit dec);
    return dec ? 4'd9 : 4'd15;
  endfunction

  function automatic logic [3:0] ref_next(logic [3:0] cur, bit dec, logic c, logic l,
                                          logic p, logic t, logic [3:0] d);
    if (!c) return 4'd0;
    if (!l) return d;
    if (p && t) return (cur == term_of(dec)) ? 4'd0 : cur + 4'd1;
    return cur;
  endfunction

  function automatic string op_tag(logic [3:0] cur, bit dec, logic c, logic l, logic p, logic t);
    if (!c) return "R1";
    if (!l) return "R4";
    if (!(p && t)) return "R5";
    if (cur == term_of(dec)) return "R7";
    if (dec && cur > 4'd9) return "R8";
    return "R6";
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic c, logic l, logic p, logic t, logic [3:0] d,
                      logic ct, logic [11:0] cd);
    logic [3:0]  exp [4];
    logic [11:0] cexp;
    string       tg [4];
    @(negedge clk);
    clr_n = c; load_n = l; en_p = p; en_t = t; din = d; ct0 = ct; cdin = cd;
    #1;
    if (!c) begin
      for (int v = 0; v < 4; v++) begin
        if (VASYNC[v]) chk(qv[v] == 4'd0, "R2", qv[v], 0);
        else           chk(qv[v] == mdl[v], "R3", qv[v], mdl[v]);
      end
    end
    for (int v = 0; v < 4; v++) begin
      exp[v] = ref_next(mdl[v], VDEC[v], c, l, p, t, d);
      tg[v]  = op_tag(mdl[v], VDEC[v], c, l, p, t);
    end
    if (!c)              cexp = '0;
    else if (!l)         cexp = cd;
    else if (p && ct)    cexp = cmdl + 12'd1;
    else                 cexp = cmdl;
    @(posedge clk);
    #1;
    for (int v = 0; v < 4; v++) begin
      mdl[v] = exp[v];
      chk(qv[v] == exp[v], tg[v], qv[v], exp[v]);
      chk(cv[v] == (t && exp[v] == term_of(VDEC[v])), "R9", cv[v],
          int'(t && exp[v] == term_of(VDEC[v])));
    end
    cmdl = cexp;
    chk(cq == cexp, "R10", cq, cexp);
    chk(cc[2] == (ct && cexp == 12'hFFF), "R10", cc[2], int'(ct && cexp == 12'hFFF));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(posedge clk);
    #1;
    // reset state, R1
    for (int v = 0; v < 4; v++) begin
      mdl[v] = 4'd0;
      chk(qv[v] == 4'd0, "R1", qv[v], 0);
    end
    cmdl = '0;
    chk(cq == 12'd0, "R1", cq, 0);

    // load with enables low (R4), then wrap at 9 for decade, step for binary (R7, R6)
    step(1, 0, 0, 0, 4'd9, 0, 12'd0);
    step(1, 1, 1, 1, 4'd0, 1, 12'd0);
    // load 15 then count: binary wrap, decade out-of-range wrap (R7, R8)
    step(1, 0, 1, 1, 4'd15, 1, 12'hFFE);
    step(1, 1, 1, 1, 4'd0, 1, 12'd0);
    step(1, 1, 1, 1, 4'd0, 1, 12'd0);
    // decade out-of-range run from 12 (R8)
    step(1, 0, 0, 1, 4'd12, 0, 12'h0FF);
    for (int i = 0; i < 6; i++) step(1, 1, 1, 1, 4'd0, 1, 12'd0);
    // carry ignores en_p at terminal value (R9), hold with en_t low (R5)
    step(1, 0, 0, 0, 4'd9, 0, 12'hFFF);
    step(1, 1, 0, 1, 4'd0, 1, 12'd0);
    step(1, 1, 1, 0, 4'd0, 0, 12'd0);
    // clear with load and count in same cycle (R1, R2, R3)
    step(0, 0, 1, 1, 4'd7, 1, 12'h123);
    step(1, 0, 1, 1, 4'd14, 1, 12'hFF0);
    step(0, 1, 1, 1, 4'd0, 1, 12'd0);

    for (int i = 0; i < 3000; i++) begin
      logic c, l, p, t, ct;
      logic [3:0] d;
      logic [11:0] cd;
      c  = ($urandom % 16) != 0;
      l  = ($urandom % 8)  != 0;
      p  = ($urandom % 4)  != 0;
      t  = ($urandom % 4)  != 0;
      ct = ($urandom % 8)  != 0;
      d  = 4'($urandom);
      cd = (($urandom % 2) != 0) ? 12'hFF0 | 12'($urandom % 16) : 12'($urandom);
      step(c, l, p, t, d, ct, cd);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule